// File: doc/BRIEF.md
# Per-Field Enabled Alarm Matcher

This block watches a running calendar clock and compares it with a stored alarm setting once per second. The calendar and the alarm are each seven bytes. Byte 0 is seconds, byte 1 minutes, byte 2 hours, byte 3 weekday, byte 4 date, byte 5 month and byte 6 year. In each alarm byte, bit 7 decides whether that field takes part in the comparison, and the low bits hold the value to compare against.

When every field that takes part equals the live time, and at least one field takes part, the block sets a sticky pending flag on the second tick. The interrupt output is the pending flag gated by an interrupt-enable input. The host clears the flag with a one-cycle clear strobe. Keeping the time and loading the alarm bytes are done by neighbouring blocks.

Top module: `alarm_matcher`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `pend_o` and `irq_o` are 0.
- R2: A field takes part in the comparison only when bit 7 of its alarm byte is 1. A participating field matches when its value bits equal the value bits of the live time byte. The value bits are 7 for seconds, minutes, weekday and year, 5 for hours and date, and 4 for month.
- R3: Bit 7 of each live time byte, and any bits above the value width of a field, play no part in the comparison.
- R4: `pend_o` is set only at a clock edge where `tick_i` is 1 and every participating field matches. It is 1 after that edge. If `tick_i` is 0, a full match does not set it.
- R5: If no alarm byte has bit 7 set, the alarm is disabled and a tick never sets `pend_o`, whatever the stored values are.
- R6: Once set, `pend_o` stays 1 until a clock edge where `clr_i` is 1. After such an edge it is 0, except when a new match is taken at the same edge; in that case it stays 1.
- R7: `irq_o` is 1 exactly when `pend_o` is 1 and `irq_en_i` is 1. It follows `irq_en_i` in the same cycle.
- R8: A field whose enable bit is 0 never blocks a match, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse once per second that starts an evaluation |
| time_i | input | 56 | Live calendar bytes; byte k is at bits 8k+7 to 8k |
| alarm_i | input | 56 | Alarm bytes in the same order; bit 7 of each byte enables that field |
| irq_en_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Clear strobe for the pending flag |
| pend_o | output | 1 | Sticky pending-alarm status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the corner cases where a plausible mistake still gives a believable alarm.

- **Field width:** the time bytes carry stray high bits and bit 7 set. A design that compares whole bytes would miss the match.
- **No field enabled:** all enable bits are clear. A plain AND of the per-field hits would fire on every tick.
- **Disabled field differs:** a field with its enable bit clear holds a different value. A design that ignores the enable bits would never fire.
- **Clear and new match together:** a clear arrives in the same cycle as a new match. A design that gives the clear priority would lose that event.
- **Match without a tick:** a full match is held while the tick is low. A design that does not gate on the tick would set the flag without it.

// File: rtl/alm_pkg.sv
// Package: shared sizes and per-field value masks for the alarm matcher.
// Assumes seven byte-wide calendar fields in the order sec, min, hour,
// weekday, date, month, year.
package alm_pkg;
    localparam int NF     = 7;
    localparam int BYTE_W = 8;
    localparam int EN_BIT = BYTE_W - 1;

    // Value bits that take part in the comparison for field idx.
    function automatic logic [BYTE_W-1:0] field_mask(input int idx);
        case (idx)
            2:       field_mask = 8'h1F; // hours, 24-hour coding
            4:       field_mask = 8'h1F; // date
            5:       field_mask = 8'h0F; // month
            default: field_mask = 8'h7F; // sec, min, weekday, year
        endcase
    endfunction
endpackage

// File: rtl/alm_field_cmp.sv
// Compares one live time byte with one alarm byte.
// Reports whether the field is enabled and whether it does not block a match.
// Assumes bit EN_BIT of the alarm byte is the enable bit.
module alm_field_cmp #(
    parameter int                BYTE_W = alm_pkg::BYTE_W,
    parameter logic [BYTE_W-1:0] MASK   = 8'h7F
) (
    input  logic [BYTE_W-1:0] time_b,
    input  logic [BYTE_W-1:0] alarm_b,
    output logic              en_o,
    output logic              hit_o
);
    localparam int EN_POS = BYTE_W - 1;

    // Masked equality; a disabled field always counts as a hit.
    always_comb begin
        en_o  = alarm_b[EN_POS];
        hit_o = !en_o || ((time_b & MASK) == (alarm_b & MASK));
    end
endmodule

// File: rtl/alm_match_tree.sv
// Reduces the per-field results to a single match qualifier.
// The match needs all fields to hit and at least one field to be enabled.
module alm_match_tree #(
    parameter int NF = alm_pkg::NF
) (
    input  logic [NF-1:0] hit_i,
    input  logic [NF-1:0] en_i,
    output logic          match_o
);
    // All fields hit and the alarm is armed.
    always_comb match_o = (&hit_i) && (|en_i);
endmodule

// File: rtl/alm_pend_reg.sv
// Sticky pending flag.
// Set on a tick that sees a match, cleared by a strobe. Set wins over clear.
// Synchronous active-low reset.
module alm_pend_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic match_i,
    input  logic clr_i,
    output logic pend_o
);
    // Capture a match on a tick, hold it, drop it on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_o <= 1'b0;
        else if (tick_i && match_i) pend_o <= 1'b1;
        else if (clr_i)             pend_o <= 1'b0;
    end
endmodule

// File: rtl/alarm_matcher.sv
// Top of the per-field enabled alarm matcher.
// It compares NF calendar bytes with NF alarm bytes, one comparator per field.
// On a matching second tick it sets a sticky pending flag.
// The interrupt is the pending flag gated by irq_en_i.
// Assumes tick_i is a single-cycle pulse.
module alarm_matcher #(
    parameter int NF     = alm_pkg::NF,
    parameter int BYTE_W = alm_pkg::BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [NF*BYTE_W-1:0] time_i,
    input  logic [NF*BYTE_W-1:0] alarm_i,
    input  logic                 irq_en_i,
    input  logic                 clr_i,
    output logic                 pend_o,
    output logic                 irq_o
);
    logic [NF-1:0] en_v;
    logic [NF-1:0] hit_v;
    logic          match;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        alm_field_cmp #(
            .BYTE_W(BYTE_W),
            .MASK  (alm_pkg::field_mask(g))
        ) u_cmp (
            .time_b (time_i [g*BYTE_W +: BYTE_W]),
            .alarm_b(alarm_i[g*BYTE_W +: BYTE_W]),
            .en_o   (en_v[g]),
            .hit_o  (hit_v[g])
        );
    end

    alm_match_tree #(.NF(NF)) u_tree (
        .hit_i  (hit_v),
        .en_i   (en_v),
        .match_o(match)
    );

    alm_pend_reg u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .match_i(match),
        .clr_i  (clr_i),
        .pend_o (pend_o)
    );

    // Interrupt request is the pending flag gated by the enable.
    always_comb irq_o = pend_o && irq_en_i;
endmodule

// File: rtl/alarm_matcher_chk.sv
// Checker bound to alarm_matcher. It observes ports only.
module alarm_matcher_chk #(
    parameter int NF     = alm_pkg::NF,
    parameter int BYTE_W = alm_pkg::BYTE_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_i,
    input logic [NF*BYTE_W-1:0] alarm_i,
    input logic                 irq_en_i,
    input logic                 clr_i,
    input logic                 pend_o,
    input logic                 irq_o
);
    logic any_en;

    // Whether any alarm byte carries its enable bit.
    always_comb begin
        any_en = 1'b0;
        for (int k = 0; k < NF; k++) any_en = any_en | alarm_i[k*BYTE_W + BYTE_W - 1];
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !pend_o);

    // R4
    set_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(tick_i));

    // R5
    disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !any_en) |=> !pend_o);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);

    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !tick_i) |=> !pend_o);

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o && irq_en_i));
endmodule

bind alarm_matcher alarm_matcher_chk #(.NF(NF), .BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .alarm_i (alarm_i),
    .irq_en_i(irq_en_i),
    .clr_i   (clr_i),
    .pend_o  (pend_o),
    .irq_o   (irq_o)
);

// File: tb/tb_alarm_matcher.sv
module tb_alarm_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [55:0] time_i = '0;
    logic [55:0] alarm_i = '0;
    logic        irq_en_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        pend_o, irq_o;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    alarm_matcher dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .time_i(time_i),
        .alarm_i(alarm_i), .irq_en_i(irq_en_i), .clr_i(clr_i),
        .pend_o(pend_o), .irq_o(irq_o)
    );

    // Bytes in the order: year, month, date, weekday, hour, min, sec.
    function automatic logic [55:0] pk(input logic [7:0] y, mo, d, w, h, mi, s);
        return {y, mo, d, w, h, mi, s};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Advance one clock edge and sample just after it.
    task automatic step();
        @(posedge clk); #1;
    endtask

    // Pulse tick for exactly one edge.
    task automatic do_tick();
        @(negedge clk); tick_i = 1'b1;
        step();
        tick_i = 1'b0;
    endtask

    // Pulse the clear strobe for exactly one edge.
    task automatic do_clr();
        @(negedge clk); clr_i = 1'b1;
        step();
        clr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; irq_en_i = 1'b1;
        step(); step();
        chk("R1 pend in reset", pend_o, 1'b0);
        chk("R1 irq in reset", irq_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        step();
        chk("R1 pend after release", pend_o, 1'b0);
    endtask

    task automatic t_basic_match();
        time_i  = pk(8'h18, 8'h06, 8'h0F, 8'h04, 8'h0A, 8'h1E, 8'h2D);
        alarm_i = pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h8A, 8'h9E, 8'hAD);
        step(); step();
        chk("R4 match without tick", pend_o, 1'b0);
        do_tick();
        chk("R2 R4 match on tick", pend_o, 1'b1);
        do_clr();
    endtask

    task automatic t_mismatch();
        time_i  = pk(8'h18, 8'h06, 8'h0F, 8'h04, 8'h0A, 8'h1F, 8'h2D);
        alarm_i = pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h8A, 8'h9E, 8'hAD);
        do_tick();
        chk("R2 minute mismatch", pend_o, 1'b0);
    endtask

    task automatic t_disabled_field();
        time_i  = pk(8'h19, 8'h06, 8'h0F, 8'h02, 8'h0A, 8'h1E, 8'h2D);
        alarm_i = pk(8'h05, 8'h00, 8'h00, 8'h40, 8'h8A, 8'h9E, 8'hAD);
        do_tick();
        chk("R8 disabled fields differ", pend_o, 1'b1);
        do_clr();
    endtask

    task automatic t_disarmed();
        time_i  = pk(8'h18, 8'h06, 8'h0F, 8'h04, 8'h0A, 8'h1E, 8'h2D);
        alarm_i = pk(8'h18, 8'h06, 8'h0F, 8'h04, 8'h0A, 8'h1E, 8'h2D);
        do_tick(); do_tick();
        chk("R5 no enable bit", pend_o, 1'b0);
    endtask

    task automatic t_width();
        // Seconds byte has bit 7 set; hour bits 5 and 6 set; month bit 4 set.
        time_i  = pk(8'h18, 8'h13, 8'h0F, 8'h04, 8'h6A, 8'h1E, 8'hAD);
        alarm_i = pk(8'h00, 8'h83, 8'h00, 8'h00, 8'h8A, 8'h9E, 8'hAD);
        do_tick();
        chk("R3 high bits ignored", pend_o, 1'b1);
    endtask

    task automatic t_sticky_clear();
        // The flag is already set here; ticks with no match must not drop it.
        time_i = pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        do_tick(); step();
        chk("R6 sticky", pend_o, 1'b1);
        do_clr();
        chk("R6 clear", pend_o, 1'b0);
    endtask

    task automatic t_set_vs_clear();
        time_i  = pk(8'h18, 8'h06, 8'h0F, 8'h04, 8'h0A, 8'h1E, 8'h2D);
        alarm_i = pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h8A, 8'h9E, 8'hAD);
        @(negedge clk); tick_i = 1'b1; clr_i = 1'b1;
        step();
        tick_i = 1'b0; clr_i = 1'b0;
        chk("R6 set beats clear", pend_o, 1'b1);
    endtask

    task automatic t_irq();
        @(negedge clk); irq_en_i = 1'b0; #1;
        chk("R7 irq masked", irq_o, 1'b0);
        irq_en_i = 1'b1; #1;
        chk("R7 irq enabled", irq_o, 1'b1);
        do_clr();
        chk("R7 irq drops with pend", irq_o, 1'b0);
    endtask

    initial begin
        t_reset();
        t_basic_match();
        t_mismatch();
        t_disabled_field();
        t_disarmed();
        t_width();
        t_sticky_clear();
        t_set_vs_clear();
        t_irq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule